// File: doc/BRIEF.md
# Priority Interrupt Presentation Unit

This block sits next to one processor and decides which interrupt, if any, that processor is shown. It holds at most one pending source, together with the priority of that source, and drives one level-sensitive interrupt line. Source controllers offer interrupts as a source number with a priority. The processor side has two priority registers: its own current priority and an inter-processor request priority. It also has an accept read, an end-of-interrupt write and a side-effect-free poll read. A smaller number is a more favoured priority, and the value 0xFF is the least favoured level.

Whenever the unit refuses or displaces a source, it hands that source back to the source controller as a reject command. When the processor priority is relaxed or an interrupt completes, the unit asks the source controller to resend what it holds. It also forwards end-of-interrupt notices. These commands wait in a small queue and leave one per cycle over a valid/ready port. While the queue cannot take the worst-case number of commands that one operation can produce, new operations and deliveries are held off.

Top module: `intr_present_unit`

## Requirements
- R1: After reset the interrupt line is low, the status word (processor priority in bits 31:24, pending source in bits 23:0) reads zero, the request priority reads 0xFF and no command is offered.
- R2: A delivery whose priority is below the processor priority, with nothing pending, is stored as the pending source and priority. The line is raised one cycle after the delivery is taken, and no command is issued.
- R3: A delivery whose priority is equal to or above the processor priority is refused: a reject command (cmd_op 0) carrying its source number is issued and the pending state is left unchanged.
- R4: A delivery that is acceptable and strictly more favoured than the pending source first issues a reject for the old source and then replaces it. The line stays high.
- R5: A delivery is refused with a reject for its own source when the pending source has a priority equal to or more favoured than it.
- R6: An accept (op_kind 2) returns the full status word on rd_status with rd_valid. It then clears the source field, moves the pending priority into the processor priority, resets the pending priority to 0xFF and lowers the line.
- R7: Writing the request priority (op_kind 1, value in op_data[7:0]) always stores it. When the value is below the processor priority and no pending source is at or better than it, the unit posts an inter-processor interrupt. Posting rejects any pending source, loads source code 2, takes the request priority as the pending priority and raises the line. Otherwise the write has no other effect.
- R8: Writing a more favoured processor priority (op_kind 0, value in op_data[7:0]) that is at or below the pending priority clears the source field, lowers the line and rejects the old source. A more favoured write with nothing pending issues no command.
- R9: Writing a processor priority that is not more favoured than the current one runs the resend sequence. First the inter-processor check of R7 runs if the request priority is below the new processor priority. Then a resend command (cmd_op 1, source 0) is issued.
- R10: An end-of-interrupt write (op_kind 3) loads bits 31:24 of op_data into the processor priority. It issues an end-of-interrupt command (cmd_op 2) carrying bits 23:0 and then runs the resend sequence, with commands leaving in that order.
- R11: A poll (op_kind 4) returns the status word on rd_status and the request priority on rd_ipi_prio, with rd_valid, and changes no state. rd_valid is high only in the cycle after an accept or poll is taken.
- R12: While the command queue lacks room for three commands, op_ready and dlv_ready stay low and the offered command holds steady. Once the consumer drains it, the stalled operation is taken exactly once and the queued commands leave in issue order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dlv_valid | input | 1 | Delivery request present |
| dlv_ready | output | 1 | Delivery taken this cycle when valid |
| dlv_src | input | SRC_W | Source number of the delivery |
| dlv_prio | input | PRIO_W | Priority of the delivery |
| op_valid | input | 1 | Processor-side operation present |
| op_ready | output | 1 | Operation taken this cycle when valid |
| op_kind | input | 3 | 0 set processor priority, 1 set request priority, 2 accept, 3 end of interrupt, 4 poll |
| op_data | input | PRIO_W+SRC_W | Write value of the operation |
| rd_valid | output | 1 | Read result present (one cycle) |
| rd_status | output | PRIO_W+SRC_W | Status word returned by accept or poll |
| rd_ipi_prio | output | PRIO_W | Request priority returned by poll |
| irq_out | output | 1 | Interrupt line to the processor |
| cmd_valid | output | 1 | Command to the source controller present |
| cmd_ready | input | 1 | Source controller takes the command |
| cmd_op | output | 2 | 0 reject, 1 resend, 2 end of interrupt |
| cmd_src | output | SRC_W | Source number carried by the command |

## Verification
Every operation or delivery is taken on the edge where its valid meets its ready. The pending state, irq_out, rd_valid and the read values then change on that edge, and queued commands become visible on cmd_valid in the same cycle. The checks therefore sample on the falling edge that follows the taking edge. Commands leave one per cycle while cmd_ready is high. A monitor records them half a cycle before the edge that consumes them, and each scenario waits a few cycles before comparing the recorded list with the expected order. The back-pressure scenario holds cmd_ready low and checks across several cycles that ready stays low and the offered command does not move.

// File: rtl/intr_present_pkg.sv
`timescale 1ns/1ps
package intr_present_pkg;

  // Commands sent back to the source controller
  typedef enum logic [1:0] {
    CMD_REJECT = 2'd0,
    CMD_RESEND = 2'd1,
    CMD_EOI    = 2'd2
  } cmd_op_e;

  // Processor-side operations
  typedef enum logic [2:0] {
    OP_SET_CPPR = 3'd0,
    OP_SET_IPI  = 3'd1,
    OP_ACCEPT   = 3'd2,
    OP_EOI      = 3'd3,
    OP_POLL     = 3'd4
  } reg_op_e;

  // Worst case number of commands one operation can generate
  localparam int MAX_CMDS = 3;

endpackage

// File: rtl/intr_present_cmdq.sv
`timescale 1ns/1ps
module intr_present_cmdq
  import intr_present_pkg::*;
#(
  parameter int DEPTH    = 4,
  parameter int SRC_W    = 24,
  parameter int MAX_PUSH = MAX_CMDS,
  localparam int PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W   = $clog2(DEPTH + 1),
  localparam int PN_W    = $clog2(MAX_PUSH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PN_W-1:0]  push_n,
  input  cmd_op_e          push_op  [MAX_PUSH],
  input  logic [SRC_W-1:0] push_src [MAX_PUSH],
  output logic             room,
  input  logic             pop,
  output logic             head_valid,
  output cmd_op_e          head_op,
  output logic [SRC_W-1:0] head_src,
  output logic [CNT_W-1:0] level
);

  cmd_op_e          mem_op  [DEPTH];
  logic [SRC_W-1:0] mem_src [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;

  // Storage carries no reset so it can map onto plain memory
  always_ff @(posedge clk) begin
    for (int k = 0; k < MAX_PUSH; k++) begin
      if (k < int'(push_n)) begin
        mem_op [wr_ptr + PTR_W'(k)] <= push_op[k];
        mem_src[wr_ptr + PTR_W'(k)] <= push_src[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr + PTR_W'(push_n);
      rd_ptr <= rd_ptr + PTR_W'(pop);
      count  <= count + CNT_W'(push_n) - CNT_W'(pop);
    end
  end

  assign room       = (count <= CNT_W'(DEPTH - MAX_PUSH));
  assign head_valid = (count != '0);
  assign head_op    = mem_op[rd_ptr];
  assign head_src   = mem_src[rd_ptr];
  assign level      = count;

endmodule

// File: rtl/intr_present_state.sv
`timescale 1ns/1ps
module intr_present_state
  import intr_present_pkg::*;
#(
  parameter int PRIO_W  = 8,
  parameter int SRC_W   = 24,
  parameter int IPI_SRC = 2,
  localparam int WORD_W = PRIO_W + SRC_W,
  localparam int PN_W   = $clog2(MAX_CMDS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_fire,
  input  logic [2:0]        op_kind,
  input  logic [WORD_W-1:0] op_data,
  input  logic              dlv_fire,
  input  logic [SRC_W-1:0]  dlv_src,
  input  logic [PRIO_W-1:0] dlv_prio,
  output logic [PN_W-1:0]   push_n,
  output cmd_op_e           push_op  [MAX_CMDS],
  output logic [SRC_W-1:0]  push_src [MAX_CMDS],
  output logic              irq_q,
  output logic [SRC_W-1:0]  src_q,
  output logic [PRIO_W-1:0] pprio_q,
  output logic              rd_valid_q,
  output logic [WORD_W-1:0] rd_status_q,
  output logic [PRIO_W-1:0] rd_ipi_q
);

  localparam logic [PRIO_W-1:0] PRIO_IDLE = '1;
  localparam logic [SRC_W-1:0]  SRC_IPI   = SRC_W'(IPI_SRC);

  logic [PRIO_W-1:0] cppr_q, mfrr_q;
  logic [PRIO_W-1:0] n_cppr, n_pprio, n_mfrr, wr_val;
  logic [SRC_W-1:0]  n_src;
  logic              n_irq, ipi_chk, do_resend, rd_hit;
  logic [PN_W-1:0]   n;
  reg_op_e           kind;

  assign kind   = reg_op_e'(op_kind);
  assign wr_val = op_data[PRIO_W-1:0];

  always_comb begin
    n_cppr    = cppr_q;
    n_src     = src_q;
    n_pprio   = pprio_q;
    n_mfrr    = mfrr_q;
    n_irq     = irq_q;
    ipi_chk   = 1'b0;
    do_resend = 1'b0;
    rd_hit    = 1'b0;
    n         = '0;
    for (int k = 0; k < MAX_CMDS; k++) begin
      push_op[k]  = CMD_REJECT;
      push_src[k] = '0;
    end

    if (op_fire) begin
      unique case (kind)
        OP_SET_CPPR: begin
          n_cppr = wr_val;
          if (wr_val < cppr_q) begin
            // more favoured: may cut off the pending source
            if ((src_q != '0) && (wr_val <= pprio_q)) begin
              push_op[n]  = CMD_REJECT;
              push_src[n] = src_q;
              n           = n + 1'b1;
              n_src       = '0;
              n_pprio     = PRIO_IDLE;
              n_irq       = 1'b0;
            end
          end else begin
            do_resend = 1'b1;
          end
        end
        OP_SET_IPI: begin
          n_mfrr = wr_val;
          if (wr_val < cppr_q) ipi_chk = 1'b1;
        end
        OP_ACCEPT: begin
          rd_hit  = 1'b1;
          n_irq   = 1'b0;
          n_cppr  = pprio_q;
          n_src   = '0;
          n_pprio = PRIO_IDLE;
        end
        OP_EOI: begin
          n_cppr      = op_data[WORD_W-1:SRC_W];
          push_op[n]  = CMD_EOI;
          push_src[n] = op_data[SRC_W-1:0];
          n           = n + 1'b1;
          do_resend   = 1'b1;
        end
        OP_POLL: rd_hit = 1'b1;
        default: ;
      endcase
    end else if (dlv_fire) begin
      if ((dlv_prio >= cppr_q) || ((src_q != '0) && (pprio_q <= dlv_prio))) begin
        push_op[n]  = CMD_REJECT;
        push_src[n] = dlv_src;
        n           = n + 1'b1;
      end else begin
        if (src_q != '0) begin
          push_op[n]  = CMD_REJECT;
          push_src[n] = src_q;
          n           = n + 1'b1;
        end
        n_src   = dlv_src;
        n_pprio = dlv_prio;
        n_irq   = 1'b1;
      end
    end

    // resend sequence: inter-processor check first, then the resend
    if (do_resend && (n_mfrr < n_cppr)) ipi_chk = 1'b1;

    if (ipi_chk && !((n_src != '0) && (n_pprio <= n_mfrr))) begin
      if (n_src != '0) begin
        push_op[n]  = CMD_REJECT;
        push_src[n] = n_src;
        n           = n + 1'b1;
      end
      n_src   = SRC_IPI;
      n_pprio = n_mfrr;
      n_irq   = 1'b1;
    end

    if (do_resend) begin
      push_op[n]  = CMD_RESEND;
      push_src[n] = '0;
      n           = n + 1'b1;
    end
  end

  assign push_n = n;

  always_ff @(posedge clk) begin
    if (rst) begin
      cppr_q      <= '0;
      src_q       <= '0;
      pprio_q     <= PRIO_IDLE;
      mfrr_q      <= PRIO_IDLE;
      irq_q       <= 1'b0;
      rd_valid_q  <= 1'b0;
      rd_status_q <= '0;
      rd_ipi_q    <= '0;
    end else begin
      cppr_q     <= n_cppr;
      src_q      <= n_src;
      pprio_q    <= n_pprio;
      mfrr_q     <= n_mfrr;
      irq_q      <= n_irq;
      rd_valid_q <= rd_hit;
      if (rd_hit) begin
        rd_status_q <= {cppr_q, src_q};
        rd_ipi_q    <= mfrr_q;
      end
    end
  end

endmodule

// File: rtl/intr_present_unit.sv
`timescale 1ns/1ps
module intr_present_unit
  import intr_present_pkg::*;
#(
  parameter int PRIO_W     = 8,
  parameter int SRC_W      = 24,
  parameter int IPI_SRC    = 2,
  parameter int CMDQ_DEPTH = 4,
  localparam int WORD_W    = PRIO_W + SRC_W,
  localparam int CNT_W     = $clog2(CMDQ_DEPTH + 1),
  localparam int PN_W      = $clog2(MAX_CMDS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dlv_valid,
  output logic              dlv_ready,
  input  logic [SRC_W-1:0]  dlv_src,
  input  logic [PRIO_W-1:0] dlv_prio,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic [2:0]        op_kind,
  input  logic [WORD_W-1:0] op_data,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_status,
  output logic [PRIO_W-1:0] rd_ipi_prio,
  output logic              irq_out,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [1:0]        cmd_op,
  output logic [SRC_W-1:0]  cmd_src
);

  logic              room, op_fire, dlv_fire, pop;
  logic [PN_W-1:0]   push_n;
  cmd_op_e           push_op  [MAX_CMDS];
  logic [SRC_W-1:0]  push_src [MAX_CMDS];
  cmd_op_e           head_op;
  logic [SRC_W-1:0]  cur_src;
  logic [PRIO_W-1:0] cur_pprio;
  logic [CNT_W-1:0]  q_level;

  // operations win over deliveries when both are offered
  assign op_ready  = room;
  assign dlv_ready = room && !op_valid;
  assign op_fire   = op_valid && op_ready;
  assign dlv_fire  = dlv_valid && dlv_ready;
  assign pop       = cmd_valid && cmd_ready;
  assign cmd_op    = head_op;

  intr_present_state #(
    .PRIO_W (PRIO_W),
    .SRC_W  (SRC_W),
    .IPI_SRC(IPI_SRC)
  ) u_state (
    .clk        (clk),
    .rst        (rst),
    .op_fire    (op_fire),
    .op_kind    (op_kind),
    .op_data    (op_data),
    .dlv_fire   (dlv_fire),
    .dlv_src    (dlv_src),
    .dlv_prio   (dlv_prio),
    .push_n     (push_n),
    .push_op    (push_op),
    .push_src   (push_src),
    .irq_q      (irq_out),
    .src_q      (cur_src),
    .pprio_q    (cur_pprio),
    .rd_valid_q (rd_valid),
    .rd_status_q(rd_status),
    .rd_ipi_q   (rd_ipi_prio)
  );

  intr_present_cmdq #(
    .DEPTH   (CMDQ_DEPTH),
    .SRC_W   (SRC_W),
    .MAX_PUSH(MAX_CMDS)
  ) u_cmdq (
    .clk       (clk),
    .rst       (rst),
    .push_n    (push_n),
    .push_op   (push_op),
    .push_src  (push_src),
    .room      (room),
    .pop       (pop),
    .head_valid(cmd_valid),
    .head_op   (head_op),
    .head_src  (cmd_src),
    .level     (q_level)
  );

endmodule

// File: rtl/intr_present_chk.sv
`timescale 1ns/1ps
module intr_present_chk #(
  parameter int PRIO_W = 8,
  parameter int SRC_W  = 24,
  parameter int DEPTH  = 4,
  parameter int CNT_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              op_valid,
  input logic              op_ready,
  input logic [2:0]        op_kind,
  input logic              dlv_ready,
  input logic              rd_valid,
  input logic              irq_out,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [1:0]        cmd_op,
  input logic [SRC_W-1:0]  cmd_src,
  input logic [SRC_W-1:0]  cur_src,
  input logic [PRIO_W-1:0] cur_pprio,
  input logic [CNT_W-1:0]  q_level
);

  logic op_fire, rd_fire, acc_fire;
  assign op_fire  = op_valid && op_ready;
  assign rd_fire  = op_fire && ((op_kind == 3'd2) || (op_kind == 3'd4));
  assign acc_fire = op_fire && (op_kind == 3'd2);

  // line and pending source move together (R2)
  p_line_tracks_src_r2: assert property (@(posedge clk) disable iff (rst)
    irq_out == (cur_src != '0));

  // nothing pending implies idle pending priority (R6)
  p_idle_prio_r6: assert property (@(posedge clk) disable iff (rst)
    (cur_src == '0) |-> (cur_pprio == '1));

  // accept drops the line (R6)
  p_accept_drops_r6: assert property (@(posedge clk) disable iff (rst)
    acc_fire |=> !irq_out);

  // read results follow exactly the read operations (R11)
  p_rd_after_read_r11: assert property (@(posedge clk) disable iff (rst)
    rd_fire |=> rd_valid);
  p_rd_only_read_r11: assert property (@(posedge clk) disable iff (rst)
    !rd_fire |=> !rd_valid);

  // offered command holds while stalled (R12)
  p_cmd_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_src) && $stable(cmd_op)));

  // no room means no intake (R12)
  p_stall_r12: assert property (@(posedge clk) disable iff (rst)
    (int'(q_level) > DEPTH - 3) |-> (!op_ready && !dlv_ready));

  // queue never exceeds its depth (R12)
  p_no_overflow_r12: assert property (@(posedge clk) disable iff (rst)
    int'(q_level) <= DEPTH);

endmodule

bind intr_present_unit intr_present_chk #(
  .PRIO_W(PRIO_W),
  .SRC_W (SRC_W),
  .DEPTH (CMDQ_DEPTH),
  .CNT_W (CNT_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .op_valid (op_valid),
  .op_ready (op_ready),
  .op_kind  (op_kind),
  .dlv_ready(dlv_ready),
  .rd_valid (rd_valid),
  .irq_out  (irq_out),
  .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready),
  .cmd_op   (cmd_op),
  .cmd_src  (cmd_src),
  .cur_src  (cur_src),
  .cur_pprio(cur_pprio),
  .q_level  (q_level)
);

// File: tb/intr_present_unit_tb.sv
`timescale 1ns/1ps
module intr_present_unit_tb;

  localparam logic [2:0] K_CPPR = 3'd0, K_IPI = 3'd1, K_ACC = 3'd2, K_EOI = 3'd3, K_POLL = 3'd4;
  localparam logic [1:0] C_REJ = 2'd0, C_RES = 2'd1, C_EOI = 2'd2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        dlv_valid = 1'b0, dlv_ready;
  logic [23:0] dlv_src = '0;
  logic [7:0]  dlv_prio = '0;
  logic        op_valid = 1'b0, op_ready;
  logic [2:0]  op_kind = '0;
  logic [31:0] op_data = '0;
  logic        rd_valid;
  logic [31:0] rd_status;
  logic [7:0]  rd_ipi_prio;
  logic        irq_out, cmd_valid;
  logic        cmd_ready = 1'b1;
  logic [1:0]  cmd_op;
  logic [23:0] cmd_src;

  int n_checks = 0, n_fail = 0;
  bit done = 0;
  logic [25:0] got_q[$];
  logic [31:0] last_rd;
  logic [7:0]  last_ipi;
  logic        last_rdv;

  always #2.5 clk = ~clk;

  intr_present_unit u_dut (
    .clk(clk), .rst(rst),
    .dlv_valid(dlv_valid), .dlv_ready(dlv_ready), .dlv_src(dlv_src), .dlv_prio(dlv_prio),
    .op_valid(op_valid), .op_ready(op_ready), .op_kind(op_kind), .op_data(op_data),
    .rd_valid(rd_valid), .rd_status(rd_status), .rd_ipi_prio(rd_ipi_prio),
    .irq_out(irq_out), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_src(cmd_src)
  );

  // source-side model: records each command before the edge that takes it
  always @(negedge clk) begin
    #1;
    if (!rst && cmd_valid && cmd_ready) got_q.push_back({cmd_op, cmd_src});
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_op(input logic [2:0] kind, input logic [31:0] data);
    @(negedge clk);
    op_valid = 1'b1; op_kind = kind; op_data = data;
    #1;
    while (!op_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    last_rdv = rd_valid; last_rd = rd_status; last_ipi = rd_ipi_prio;
    op_valid = 1'b0;
  endtask

  task automatic deliver(input logic [23:0] src, input logic [7:0] prio);
    @(negedge clk);
    dlv_valid = 1'b1; dlv_src = src; dlv_prio = prio;
    #1;
    while (!dlv_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    dlv_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic poll_check(input string tag, input logic [31:0] st, input logic [7:0] ipi);
    do_op(K_POLL, 32'h0);
    check({tag, " poll valid"}, {31'h0, last_rdv}, 32'h1);
    check({tag, " poll status"}, last_rd, st);
    check({tag, " poll ipi"}, {24'h0, last_ipi}, {24'h0, ipi});
  endtask

  task automatic expect_cmd(input string tag, input logic [1:0] op, input logic [23:0] src);
    logic [25:0] g;
    n_checks++;
    if (got_q.size() == 0) begin
      n_fail++;
      $display("FAIL %s actual=none expected=%h", tag, {op, src});
    end else begin
      g = got_q.pop_front();
      if (g !== {op, src}) begin
        n_fail++;
        $display("FAIL %s actual=%h expected=%h", tag, g, {op, src});
      end
    end
  endtask

  task automatic expect_quiet(input string tag);
    check({tag, " extra cmds"}, got_q.size(), 0);
    got_q.delete();
  endtask

  task automatic t_reset();
    check("R1 irq", {31'h0, irq_out}, 32'h0);
    check("R1 cmd_valid", {31'h0, cmd_valid}, 32'h0);
    poll_check("R1", 32'h0, 8'hFF);
    settle(); expect_quiet("R1");
  endtask

  task automatic t_deliver();
    do_op(K_CPPR, 32'h10);            // not more favoured than 0: resend
    settle(); expect_cmd("R9 resend", C_RES, 24'h0); expect_quiet("R9");
    deliver(24'h40, 8'h05);
    check("R2 irq", {31'h0, irq_out}, 32'h1);
    settle(); expect_quiet("R2");
    poll_check("R2", 32'h1000_0040, 8'hFF);
  endtask

  task automatic t_refuse();
    deliver(24'h41, 8'h10);
    settle(); expect_cmd("R3 reject", C_REJ, 24'h41); expect_quiet("R3");
    deliver(24'h43, 8'h05);
    settle(); expect_cmd("R5 reject", C_REJ, 24'h43); expect_quiet("R5");
    check("R5 irq", {31'h0, irq_out}, 32'h1);
    poll_check("R5", 32'h1000_0040, 8'hFF);
  endtask

  task automatic t_displace();
    deliver(24'h42, 8'h03);
    check("R4 irq", {31'h0, irq_out}, 32'h1);
    settle(); expect_cmd("R4 reject old", C_REJ, 24'h40); expect_quiet("R4");
    poll_check("R11 first", 32'h1000_0042, 8'hFF);
    poll_check("R11 second", 32'h1000_0042, 8'hFF);
    check("R11 irq kept", {31'h0, irq_out}, 32'h1);
  endtask

  task automatic t_accept_eoi();
    do_op(K_ACC, 32'h0);
    check("R6 rd valid", {31'h0, last_rdv}, 32'h1);
    check("R6 rd status", last_rd, 32'h1000_0042);
    check("R6 irq", {31'h0, irq_out}, 32'h0);
    poll_check("R6", 32'h0300_0000, 8'hFF);
    settle(); expect_quiet("R6");
    do_op(K_EOI, 32'hFF00_0042);
    settle();
    expect_cmd("R10 eoi", C_EOI, 24'h42);
    expect_cmd("R10 resend", C_RES, 24'h0);
    expect_quiet("R10");
    poll_check("R10", 32'hFF00_0000, 8'hFF);
  endtask

  task automatic t_ipi();
    do_op(K_IPI, 32'h20);
    check("R7 irq", {31'h0, irq_out}, 32'h1);
    poll_check("R7 post", 32'hFF00_0002, 8'h20);
    settle(); expect_quiet("R7 post");
    deliver(24'h50, 8'h10);
    settle(); expect_cmd("R4 reject ipi", C_REJ, 24'h2); expect_quiet("R4 ipi");
    do_op(K_IPI, 32'h30);             // pending 0x10 is better: no post
    settle(); expect_quiet("R7 blocked");
    poll_check("R7 blocked", 32'hFF00_0050, 8'h30);
    do_op(K_IPI, 32'h08);             // beats pending: post and reject
    settle(); expect_cmd("R7 reject", C_REJ, 24'h50); expect_quiet("R7 repost");
    poll_check("R7 repost", 32'hFF00_0002, 8'h08);
  endtask

  task automatic t_cut();
    do_op(K_CPPR, 32'h05);
    check("R8 irq", {31'h0, irq_out}, 32'h0);
    settle(); expect_cmd("R8 reject", C_REJ, 24'h2); expect_quiet("R8");
    poll_check("R8", 32'h0500_0000, 8'h08);
    do_op(K_CPPR, 32'h04);
    settle(); expect_quiet("R8 idle");
    do_op(K_IPI, 32'h06);             // not below 4: stored only
    check("R7 no post irq", {31'h0, irq_out}, 32'h0);
    settle(); expect_quiet("R7 no post");
    poll_check("R7 no post", 32'h0400_0000, 8'h06);
  endtask

  task automatic t_resend();
    do_op(K_CPPR, 32'h07);            // relax: IPI check then resend
    check("R9 irq", {31'h0, irq_out}, 32'h1);
    settle(); expect_cmd("R9 resend", C_RES, 24'h0); expect_quiet("R9 ipi");
    poll_check("R9", 32'h0700_0002, 8'h06);
    do_op(K_ACC, 32'h0);
    check("R6 ipi accept", last_rd, 32'h0700_0002);
    poll_check("R6 ipi", 32'h0600_0000, 8'h06);
    do_op(K_EOI, 32'hFF00_0002);
    check("R10 irq", {31'h0, irq_out}, 32'h1);
    settle();
    expect_cmd("R10 eoi2", C_EOI, 24'h2);
    expect_cmd("R10 resend2", C_RES, 24'h0);
    expect_quiet("R10 ipi");
    poll_check("R10 ipi", 32'hFF00_0002, 8'h06);
  endtask

  task automatic t_backpressure();
    cmd_ready = 1'b0;
    deliver(24'h90, 8'hFF);
    deliver(24'h91, 8'hFF);
    @(negedge clk);
    op_valid = 1'b1; op_kind = K_IPI; op_data = 32'hFF;
    for (int i = 0; i < 3; i++) begin
      #1;
      check("R12 op stalled", {31'h0, op_ready}, 32'h0);
      check("R12 dlv stalled", {31'h0, dlv_ready}, 32'h0);
      check("R12 head held", {6'h0, cmd_op, cmd_src}, {6'h0, C_REJ, 24'h90});
      @(negedge clk);
    end
    cmd_ready = 1'b1;
    #1;
    while (!op_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    op_valid = 1'b0;
    settle();
    expect_cmd("R12 first", C_REJ, 24'h90);
    expect_cmd("R12 second", C_REJ, 24'h91);
    expect_quiet("R12");
    poll_check("R12", 32'hFF00_0002, 8'hFF);
    check("R12 irq", {31'h0, irq_out}, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_deliver();
    t_refuse();
    t_displace();
    t_accept_eoi();
    t_ipi();
    t_cut();
    t_resend();
    t_backpressure();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

endmodule